// File: doc/BRIEF.md
# Sequential Prefetching Memory Read Controller

This block connects a 32-bit read-only bus port to a slow memory whose locations are 64 bits wide and take several cycles to produce data. Each bus read names a byte address. The controller maps that address to a memory location and returns the 32-bit half that the address selects. It keeps the most recently read location in a one-entry buffer, so a second read of the same location is answered without touching the memory.

When read-ahead is enabled, serving the upper half of a location starts a speculative read of the next location. Incrementing reads then overlap memory latency with bus activity. A non-sequential read that arrives while such a speculative read is in flight waits for it to complete, and only then starts its own read. The slow-read mode overrides read-ahead and bypasses the buffer entirely, so every bus read becomes one memory read.

The bus holds `bus_req` and `bus_addr` until `bus_ready` pulses for one cycle with the data. The memory side holds `mem_req` and `mem_addr` until `mem_ack` pulses, and `mem_rdata` is valid in that same cycle.

Top module: `prefetch_read_ctrl`

## Requirements
- R1: With slow-read at 0, a read whose location equals the buffered location is answered in the cycle it is presented (no wait cycle), and no memory read is made for it.
- R2: A read that misses while no memory read is in flight raises `mem_req` in the next cycle, with `mem_addr` equal to `bus_addr[15:3]`. The data is returned in the cycle `mem_ack` is high.
- R3: Address bit 2 selects the half: 1 returns `mem_rdata[63:32]` of the location, and 0 returns bits `[31:0]`.
- R4: With read-ahead at 1 and slow-read at 0, serving a read with address bit 2 set, while no memory read is pending (or in the cycle one completes), starts a read of location+1 in the next cycle. Each location of an incrementing stream is read exactly once.
- R5: A read of the location being fetched speculatively is answered in the cycle that fetch is acknowledged.
- R6: A read that misses both the buffer and an in-flight speculative read waits for that read's acknowledge. Its own memory read starts in the next cycle.
- R7: With slow-read at 1, every bus read causes its own memory read, and data is returned only in an acknowledge cycle. Incrementing reads therefore read each location twice.
- R8: Slow-read takes priority over read-ahead: with both at 1, no speculative read is started.
- R9: After reset, `bus_ready` and `mem_req` are low and the buffer is empty, so the first read always goes to memory.
- R10: `mem_req` and `mem_addr` stay stable until `mem_ack`, and `bus_ready` is only high while `bus_req` is high.
- R11: With read-ahead at 0, a memory read starts only for a pending missed bus read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_readahead | input | 1 | Enable speculative read of the next location |
| cfg_slowread | input | 1 | Bypass buffer and speculation; overrides read-ahead |
| bus_req | input | 1 | Bus read request, held until `bus_ready` |
| bus_addr | input | ADDR_W (16) | Byte address of the 32-bit word |
| bus_ready | output | 1 | One-cycle pulse: `bus_rdata` valid, request done |
| bus_rdata | output | DATA_W (32) | Read data |
| mem_req | output | 1 | Memory read request, held until `mem_ack` |
| mem_addr | output | ADDR_W-3 (13) | Memory location index |
| mem_ack | input | 1 | Memory read complete, `mem_rdata` valid |
| mem_rdata | input | 2*DATA_W (64) | Location contents |

## Verification
The assertions check the following on every cycle:
- the memory handshake stays stable until it is acknowledged;
- a miss from idle, or a miss left over at an acknowledge, issues the correct location in the next cycle;
- a launch targets location+1;
- slow-read data only ever comes from an acknowledge;
- no memory read starts without a missed bus read when speculation is off.

Other properties only the bench scenarios can show, by comparing the wait cycles of each access and the total memory read count against a behavioural timing model. These are:
- how many wait cycles read-ahead saves for a given latency and bus gap;
- the added delay of a non-sequential read behind a speculation;
- the doubled memory traffic in slow-read mode;
- the returned half-word data.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  // State of the single memory read slot
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DEMAND = 2'd1,
    ST_SPEC   = 2'd2
  } fetch_state_t;

endpackage

// File: rtl/pfr_line_buf.sv
// One-entry location buffer: contents, location tag and valid flag.
module pfr_line_buf #(
  parameter int LOC_W  = 13,
  parameter int LINE_W = 64,
  localparam int HALF_W = LINE_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cap_en,
  input  logic [LOC_W-1:0]  cap_loc,
  input  logic [LINE_W-1:0] cap_data,
  input  logic [LOC_W-1:0]  look_loc,
  input  logic              look_upper,
  output logic              hit,
  output logic [HALF_W-1:0] look_half
);

  logic              vld_q;
  logic [LOC_W-1:0]  tag_q;
  logic [LINE_W-1:0] dat_q;

  function automatic logic [HALF_W-1:0] half_of(input logic [LINE_W-1:0] line,
                                                input logic upper);
    return upper ? line[LINE_W-1:HALF_W] : line[HALF_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      dat_q <= '0;
    end else if (flush) begin
      vld_q <= 1'b0;
    end else if (cap_en) begin
      vld_q <= 1'b1;
      tag_q <= cap_loc;
      dat_q <= cap_data;
    end
  end

  assign hit       = vld_q && (tag_q == look_loc);
  assign look_half = half_of(dat_q, look_upper);

endmodule

// File: rtl/pfr_fetch_seq.sv
// Memory read slot: one request at a time, demand before speculation.
module pfr_fetch_seq
  import pfr_pkg::*;
#(
  parameter int LOC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_demand,
  input  logic [LOC_W-1:0] demand_loc,
  input  logic             go_spec,
  input  logic [LOC_W-1:0] spec_loc,
  input  logic             mem_ack,
  output logic             mem_req,
  output logic [LOC_W-1:0] mem_loc,
  output logic             in_demand,
  output logic             in_spec,
  output logic             slot_free
);

  fetch_state_t     st_q, st_d;
  logic [LOC_W-1:0] loc_q, loc_d;

  // The slot can take new work when idle or in the acknowledge cycle
  assign slot_free = (st_q == ST_IDLE) || mem_ack;

  always_comb begin
    st_d  = st_q;
    loc_d = loc_q;
    if (slot_free) begin
      if (go_demand) begin
        st_d  = ST_DEMAND;
        loc_d = demand_loc;
      end else if (go_spec) begin
        st_d  = ST_SPEC;
        loc_d = spec_loc;
      end else begin
        st_d  = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      loc_q <= '0;
    end else begin
      st_q  <= st_d;
      loc_q <= loc_d;
    end
  end

  assign mem_req   = (st_q != ST_IDLE);
  assign mem_loc   = loc_q;
  assign in_demand = (st_q == ST_DEMAND);
  assign in_spec   = (st_q == ST_SPEC);

endmodule

// File: rtl/pfr_resp_sel.sv
// Chooses the source of a bus response: acknowledged memory data or the buffer.
module pfr_resp_sel #(
  parameter int LOC_W  = 13,
  parameter int LINE_W = 64,
  localparam int HALF_W = LINE_W / 2
) (
  input  logic              bus_req,
  input  logic [LOC_W-1:0]  req_loc,
  input  logic              req_upper,
  input  logic              slow,
  input  logic              buf_hit,
  input  logic [HALF_W-1:0] buf_half,
  input  logic              in_demand,
  input  logic              in_spec,
  input  logic [LOC_W-1:0]  mem_loc,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata,
  output logic              from_mem,
  output logic              from_buf,
  output logic              ready,
  output logic              miss,
  output logic [HALF_W-1:0] rdata
);

  function automatic logic [HALF_W-1:0] pick_half(input logic [LINE_W-1:0] line,
                                                  input logic upper);
    return upper ? line[LINE_W-1:HALF_W] : line[HALF_W-1:0];
  endfunction

  logic loc_match;
  assign loc_match = (mem_loc == req_loc);

  // Speculative data may serve the bus only outside slow-read mode
  assign from_mem = bus_req && mem_ack && loc_match && (in_demand || (in_spec && !slow));
  assign from_buf = bus_req && buf_hit && !slow && !from_mem;
  assign ready    = from_mem || from_buf;
  assign miss     = bus_req && !ready;
  assign rdata    = from_mem ? pick_half(mem_rdata, req_upper) : buf_half;

endmodule

// File: rtl/prefetch_read_ctrl.sv
module prefetch_read_ctrl
  import pfr_pkg::*;
#(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 32,
  localparam int LINE_W = 2 * DATA_W,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int LOC_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_readahead,
  input  logic              cfg_slowread,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_req,
  output logic [LOC_W-1:0]  mem_addr,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);

  function automatic logic [LOC_W-1:0] next_loc(input logic [LOC_W-1:0] loc);
    return loc + LOC_W'(1);
  endfunction

  // Address split
  logic [LOC_W-1:0] req_loc;
  logic             req_upper;
  logic             unused_low_bits;
  assign req_loc         = bus_addr[ADDR_W-1:OFF_W];
  assign req_upper       = bus_addr[OFF_W-1];
  assign unused_low_bits = ^bus_addr[OFF_W-2:0];

  // Named internal events
  logic ev_hit, ev_from_mem, ev_serve, ev_miss, ev_launch, ev_demand;
  logic ra_active;

  logic              buf_hit;
  logic [DATA_W-1:0] buf_half;
  logic              in_demand, in_spec, slot_free;
  logic [LOC_W-1:0]  mem_loc;

  assign ra_active = cfg_readahead && !cfg_slowread;

  pfr_line_buf #(.LOC_W(LOC_W), .LINE_W(LINE_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (cfg_slowread),
    .cap_en     (mem_ack && mem_req),
    .cap_loc    (mem_loc),
    .cap_data   (mem_rdata),
    .look_loc   (req_loc),
    .look_upper (req_upper),
    .hit        (buf_hit),
    .look_half  (buf_half)
  );

  pfr_resp_sel #(.LOC_W(LOC_W), .LINE_W(LINE_W)) u_resp (
    .bus_req   (bus_req),
    .req_loc   (req_loc),
    .req_upper (req_upper),
    .slow      (cfg_slowread),
    .buf_hit   (buf_hit),
    .buf_half  (buf_half),
    .in_demand (in_demand),
    .in_spec   (in_spec),
    .mem_loc   (mem_loc),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .from_mem  (ev_from_mem),
    .from_buf  (ev_hit),
    .ready     (ev_serve),
    .miss      (ev_miss),
    .rdata     (bus_rdata)
  );

  // Speculation starts only when an upper half is served and the slot is free
  assign ev_launch = ra_active && ev_serve && req_upper && slot_free;
  assign ev_demand = ev_miss && slot_free;

  pfr_fetch_seq #(.LOC_W(LOC_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_demand  (ev_demand),
    .demand_loc (req_loc),
    .go_spec    (ev_launch),
    .spec_loc   (next_loc(req_loc)),
    .mem_ack    (mem_ack),
    .mem_req    (mem_req),
    .mem_loc    (mem_loc),
    .in_demand  (in_demand),
    .in_spec    (in_spec),
    .slot_free  (slot_free)
  );

  assign bus_ready = ev_serve;
  assign mem_addr  = mem_loc;

endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 32,
  localparam int LINE_W = 2 * DATA_W,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int LOC_W  = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_readahead,
  input logic              cfg_slowread,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ready,
  input logic              mem_req,
  input logic [LOC_W-1:0]  mem_addr,
  input logic              mem_ack,
  input logic              ev_launch
);

  logic [LOC_W-1:0] loc_now;
  assign loc_now = bus_addr[ADDR_W-1:OFF_W];

  p_ready_has_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> bus_req);

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_demand_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready && !mem_req |=> mem_req && (mem_addr == $past(loc_now)));

  p_ack_then_demand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack && bus_req && !bus_ready |=> mem_req && (mem_addr == $past(loc_now)));

  p_launch_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> mem_req && (mem_addr == $past(loc_now) + LOC_W'(1)));

  p_slow_via_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_slowread && bus_ready |-> mem_ack);

  // R11, and R8 since slow-read also disables speculation
  p_no_spec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (!$past(mem_req) || $past(mem_ack)) &&
    ($past(cfg_slowread) || !$past(cfg_readahead))
    |-> $past(bus_req && !bus_ready));

endmodule

bind prefetch_read_ctrl pfr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pfr_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_readahead (cfg_readahead),
  .cfg_slowread  (cfg_slowread),
  .bus_req       (bus_req),
  .bus_addr      (bus_addr),
  .bus_ready     (bus_ready),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_ack       (mem_ack),
  .ev_launch     (ev_launch)
);

// File: tb/prefetch_read_ctrl_bench.sv
module prefetch_read_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = AW - 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_readahead = 1'b1;
  logic          cfg_slowread = 1'b0;
  logic          bus_req = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_ready;
  logic [31:0]   bus_rdata;
  logic          mem_req;
  logic [LW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [63:0]   mem_rdata = '0;

  int vectors = 0;
  int fails = 0;
  int lat = 4;
  int hw_reads = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_read_ctrl u_prefetch_read_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_readahead(cfg_readahead), .cfg_slowread(cfg_slowread),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [63:0] line_of(input int loc);
    logic [31:0] l = 32'(loc);
    return {32'hA500_0000 | l, 32'h3C00_0000 ^ (l * 7)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory: each read takes lat cycles of mem_req, ack in the last one
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      if (!rst_n || !mem_req) begin
        cnt = 0; mem_ack = 1'b0;
      end else begin
        cnt++;
        if (cnt >= lat) begin
          mem_ack = 1'b1; mem_rdata = line_of(int'(mem_addr)); cnt = 0;
        end else mem_ack = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_ack) hw_reads++;
    if (rst_n && bus_ready && !bus_req) begin
      fails++;
      $display("FAIL R10 ready without request: actual 1 expected 0");
    end
  end

  // Behavioural timing model
  bit m_bv = 0; int m_bloc = 0;
  bit m_sp = 0; int m_sloc = 0; int m_rem = 0;
  int m_reads = 0;

  task automatic model_advance(input int n);
    if (m_sp) begin
      if (m_rem <= n) begin m_sp = 0; m_bv = 1; m_bloc = m_sloc; end
      else m_rem -= n;
    end
  endtask

  task automatic model_access(input logic [AW-1:0] a, output int w);
    int loc = int'(a[AW-1:3]);
    if (cfg_slowread) begin
      w = lat; m_reads++; m_bv = 0;
    end else if (m_sp && loc == m_sloc) begin
      w = m_rem - 1; m_sp = 0; m_bv = 1; m_bloc = loc;
    end else if (m_bv && m_bloc == loc) begin
      w = 0;
      if (m_sp) begin
        m_rem--;
        if (m_rem == 0) begin m_sp = 0; m_bloc = m_sloc; end
      end
    end else if (m_sp) begin
      w = m_rem + lat - 1; m_sp = 0; m_reads++; m_bv = 1; m_bloc = loc;
    end else begin
      w = lat; m_reads++; m_bv = 1; m_bloc = loc;
    end
    if (cfg_readahead && !cfg_slowread && a[2] && !m_sp) begin
      m_sp = 1; m_sloc = (loc + 1) % (1 << LW); m_rem = lat; m_reads++;
    end
  endtask

  task automatic do_idle(input int n);
    bus_req = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
    model_advance(n);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int gap, input string req);
    int w = 0, ew; bit done = 0;
    logic [63:0] ln;
    logic [31:0] ed;
    if (gap > 0) do_idle(gap);
    model_access(a, ew);
    ln = line_of(int'(a[AW-1:3]));
    ed = a[2] ? ln[63:32] : ln[31:0];
    bus_req = 1'b1; bus_addr = a;
    while (!done) begin
      @(negedge clk);
      if (bus_ready) begin
        chk(bus_rdata == ed, "R3", "read data", bus_rdata, ed);
        done = 1;
      end else begin
        w++;
        if (w > 2000) begin chk(0, req, "no response", w, ew); done = 1; end
      end
      @(posedge clk); #1;
    end
    bus_req = 1'b0;
    chk(w == ew, req, "wait cycles", w, ew);
  endtask

  task automatic chk_reads(input int hw0, input int m0, input string req);
    do_idle(3 * lat + 2);
    chk((hw_reads - hw0) == (m_reads - m0), req, "memory reads", hw_reads - hw0, m_reads - m0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int h0, m0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ready == 1'b0, "R9", "ready after reset", bus_ready, 0);
    chk(mem_req == 1'b0, "R9", "mem_req after reset", mem_req, 0);
    @(posedge clk); #1;

    // Read-ahead, back-to-back incrementing (R2 first miss, R1 hits, R5 spec)
    h0 = hw_reads; m0 = m_reads;
    do_read(16'h0000, 0, "R9");
    do_read(16'h0004, 0, "R1");
    for (int i = 2; i < 16; i++) do_read(AW'(i * 4), 0, "R5");
    chk_reads(h0, m0, "R4");

    // Read-ahead with bus gaps: overlap hides latency (R4)
    h0 = hw_reads; m0 = m_reads;
    for (int i = 0; i < 12; i++) do_read(AW'(16'h0800 + i * 4), 2, "R4");
    chk_reads(h0, m0, "R4");

    // Non-sequential reads behind speculation (R6)
    h0 = hw_reads; m0 = m_reads;
    do_read(16'h0104, 0, "R2");
    do_read(16'h0400, 0, "R6");
    do_read(16'h0404, 0, "R1");
    do_read(16'h0100, 0, "R6");
    do_read(16'h0104, 0, "R1");
    chk_reads(h0, m0, "R6");

    // Slow-read overrides read-ahead (R7, R8)
    cfg_slowread = 1'b1;
    h0 = hw_reads; m0 = m_reads;
    for (int i = 0; i < 8; i++) do_read(AW'(16'h0200 + i * 4), 0, "R7");
    chk_reads(h0, m0, "R8");
    chk((hw_reads - h0) == 8, "R7", "each location read twice", hw_reads - h0, 8);
    do_read(16'h021C, 0, "R7");

    // Read-ahead off (R11)
    cfg_slowread = 1'b0; cfg_readahead = 1'b0;
    h0 = hw_reads; m0 = m_reads;
    for (int i = 0; i < 8; i++) do_read(AW'(16'h0300 + i * 4), 0, "R11");
    chk_reads(h0, m0, "R11");
    chk((hw_reads - h0) == 4, "R11", "one read per location", hw_reads - h0, 4);

    // Single-cycle memory with read-ahead (R5 zero-wait sequential)
    cfg_readahead = 1'b1; lat = 1;
    h0 = hw_reads; m0 = m_reads;
    for (int i = 0; i < 8; i++) do_read(AW'(16'h0500 + i * 4), 0, "R5");
    do_read(16'h0A04, 0, "R6");
    do_read(16'h0A08, 1, "R4");
    chk_reads(h0, m0, "R4");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule